// File: doc/BRIEF.md
# Timer-Driven Square-Wave Pin Generator

This block runs an up-counting timer that restarts from a programmable start value every time it passes its top count. Each restart flips a toggle flip-flop. The toggle therefore makes a square wave whose rate is half the restart rate. With an N-bit timer of top count 2^N and a start value P, the wave frequency is the timer clock divided by 2·(2^N − P).

The wave shares one general-purpose output pin with a port data bit. The `freq_sel` strap is fixed when the chip is built. When it is low, the pin is an ordinary output that follows the port bit. When it is high, the port bit acts as a gate: 1 passes the wave to the pin and 0 forces the pin low.

A one-clock `ovf_pulse` marks every restart, so nearby logic can count or sample the timer events.

Top module: `freq_out_gen`

## Requirements
- R1: While `tmr_run` stays high, the counter advances by one per clock from the start value. On the clock after it reads the all-ones value, it reloads `preload`, sampled at that edge. `ovf_pulse` is 1 for exactly the cycle that follows each reload edge and is 0 at all other times.
- R2: The toggle flip-flop inverts at every reload edge. In frequency mode with `port_bit`=1, successive rising edges on `pin_out` are therefore 2·(256 − `preload`) clocks apart with the default 8-bit width.
- R3: On the first clock where `tmr_run` is high after being low, the counter loads `preload` and the toggle clears to 0, with no `ovf_pulse`.
- R4: With `freq_sel`=1 and `port_bit`=0, `pin_out` is 0 whatever the timer is doing.
- R5: With `freq_sel`=1 and `port_bit`=1, `pin_out` equals the toggle value.
- R6: While `tmr_run` is low, the counter and the toggle hold their values and `ovf_pulse` stays 0. In frequency mode with `port_bit`=1, the pin keeps its last level.
- R7: With `freq_sel`=0, `pin_out` equals `port_bit` at all times, whatever the timer does.
- R8: While `rst_n` is low, the counter, the toggle and `ovf_pulse` are 0, so in frequency mode the pin reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_sel | input | 1 | Build-time strap: 1 selects frequency output, 0 selects plain port output |
| tmr_run | input | 1 | Timer run enable |
| preload | input | 8 | Start and reload value of the counter |
| port_bit | input | 1 | Port data bit: the pin level in normal mode, the wave gate in frequency mode |
| pin_out | output | 1 | Level driven onto the shared pin |
| ovf_pulse | output | 1 | One-clock marker of each counter reload |

## Verification
The main function is exercised with start values 0xFE, 0xF0, 0x80 and 0x00, and with 0xFF, where a reload happens on every clock. Measuring the spacing of pin edges for each start value separates a correct 2·(256 − N) divider from off-by-one reload errors and from a wave that is not divided by two. The bench also drops `tmr_run` in the middle of a wave and toggles `port_bit` in both modes. This shows the frozen-level and gating behaviour apart from plain passthrough. A cycle-level reference model is compared with `pin_out` and `ovf_pulse` on every clock, so any drift in reload timing shows up as soon as it happens.

// File: rtl/fog_pkg.sv
package fog_pkg;

    localparam int unsigned FOG_CNT_W = 8;

    typedef struct packed {
        logic [FOG_CNT_W-1:0] cnt;
        logic                 run_seen;
        logic                 ovf;
    } fog_timer_st_t;

    typedef struct packed {
        logic tog;
    } fog_toggle_st_t;

endpackage

// File: rtl/fog_timer.sv
module fog_timer
    import fog_pkg::*;
#(
    parameter int unsigned CNT_W = FOG_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] reload_val,
    output logic             start_now,
    output logic             wrap_now,
    output logic             ovf
);

    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run_seen;
        logic             ovf;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.ovf      = 1'b0;
        st_d.run_seen = run;
        start_now     = run && !st_q.run_seen;
        wrap_now      = run && st_q.run_seen && (st_q.cnt == CNT_TOP);
        if (start_now) begin
            st_d.cnt = reload_val;
        end else if (wrap_now) begin
            st_d.cnt = reload_val;
            st_d.ovf = 1'b1;
        end else if (run) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ovf = st_q.ovf;

endmodule

// File: rtl/fog_toggle.sv
module fog_toggle
    import fog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic flip,
    output logic tog
);

    fog_toggle_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.tog = 1'b0;
        end else if (flip) begin
            st_d.tog = !st_q.tog;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tog = st_q.tog;

endmodule

// File: rtl/fog_pin_mux.sv
module fog_pin_mux (
    input  logic freq_sel,
    input  logic port_bit,
    input  logic wave,
    output logic pin
);

    always_comb begin
        if (freq_sel) begin
            pin = port_bit & wave;
        end else begin
            pin = port_bit;
        end
    end

endmodule

// File: rtl/freq_out_gen.sv
module freq_out_gen
    import fog_pkg::*;
#(
    parameter int unsigned CNT_W = FOG_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freq_sel,
    input  logic             tmr_run,
    input  logic [CNT_W-1:0] preload,
    input  logic             port_bit,
    output logic             pin_out,
    output logic             ovf_pulse
);

    logic start_now;
    logic wrap_now;
    logic tog_q;

    fog_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (tmr_run),
        .reload_val(preload),
        .start_now (start_now),
        .wrap_now  (wrap_now),
        .ovf       (ovf_pulse)
    );

    fog_toggle u_toggle (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(start_now),
        .flip (wrap_now),
        .tog  (tog_q)
    );

    fog_pin_mux u_mux (
        .freq_sel(freq_sel),
        .port_bit(port_bit),
        .wave    (tog_q),
        .pin     (pin_out)
    );

endmodule

// File: rtl/freq_out_gen_chk.sv
module freq_out_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic freq_sel,
    input logic tmr_run,
    input logic port_bit,
    input logic pin_out,
    input logic ovf_pulse,
    input logic tog_q
);

    AST_GATED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_sel && !port_bit) |-> !pin_out); // R4

    AST_WAVE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_sel && port_bit) |-> (pin_out == tog_q)); // R5

    AST_NORMAL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !freq_sel |-> (pin_out == port_bit)); // R7

    AST_FROZEN_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_run |=> ($stable(tog_q) && !ovf_pulse)); // R6

    AST_START_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_run) |=> (!ovf_pulse && !tog_q)); // R3

    AST_PULSE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_pulse && $past(rst_n)) |-> (tog_q != $past(tog_q))); // R2

endmodule

bind freq_out_gen freq_out_gen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .freq_sel (freq_sel),
    .tmr_run  (tmr_run),
    .port_bit (port_bit),
    .pin_out  (pin_out),
    .ovf_pulse(ovf_pulse),
    .tog_q    (tog_q)
);

// File: tb/freq_out_gen_bench.sv
`timescale 1ns/1ps
module freq_out_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       freq_sel = 1'b1;
    logic       tmr_run = 1'b0;
    logic [7:0] preload = 8'h00;
    logic       port_bit = 1'b0;
    logic       pin_out;
    logic       ovf_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_cnt = 0;
    int m_tog = 0;
    int m_runp = 0;
    int m_ovf = 0;

    always #4 clk = !clk;

    freq_out_gen u_freq_out_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .freq_sel (freq_sel),
        .tmr_run  (tmr_run),
        .preload  (preload),
        .port_bit (port_bit),
        .pin_out  (pin_out),
        .ovf_pulse(ovf_pulse)
    );

    // Reference model, updated at each clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_tog = 0; m_runp = 0; m_ovf = 0;
        end else begin
            m_ovf = 0;
            if (tmr_run && !m_runp) begin
                m_cnt = preload; m_tog = 0;
            end else if (tmr_run) begin
                if (m_cnt == 255) begin
                    m_cnt = preload; m_tog = 1 - m_tog; m_ovf = 1;
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end
            m_runp = tmr_run;
        end
    end

    // Compare on every clock, 2 ns after the edge
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            int exp_pin;
            exp_pin = freq_sel ? (port_bit & m_tog) : port_bit;
            checks++;
            if (pin_out !== exp_pin[0]) begin
                errors++;
                $display("FAIL R5/R7 pin_out actual=%0b expected=%0b", pin_out, exp_pin[0]);
            end
            checks++;
            if (ovf_pulse !== m_ovf[0]) begin
                errors++;
                $display("FAIL R1 ovf_pulse actual=%0b expected=%0b", ovf_pulse, m_ovf[0]);
            end
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // R2: spacing between rising pin edges
    task automatic measure_period(input logic [7:0] n);
        int t0;
        int t1;
        int cyc;
        logic prev;
        @(negedge clk);
        tmr_run = 1'b0; preload = n; port_bit = 1'b1;
        @(negedge clk);
        tmr_run = 1'b1;
        cyc = 0; t0 = -1; t1 = -1; prev = pin_out;
        while (t1 < 0 && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (pin_out && !prev) begin
                if (t0 < 0) t0 = cyc; else t1 = cyc;
            end
            prev = pin_out;
        end
        checks++;
        if ((t1 - t0) != 2 * (256 - int'(n))) begin
            errors++;
            $display("FAIL R2 period for preload %0d actual=%0d expected=%0d",
                     n, t1 - t0, 2 * (256 - int'(n)));
        end
    endtask

    initial begin
        step(3);
        // R8: reset state
        chk("R8 pin in reset", pin_out, 1'b0);
        chk("R8 ovf in reset", ovf_pulse, 1'b0);
        port_bit = 1'b1;
        #1;
        chk("R8 pin with gate open in reset", pin_out, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        step(2);

        // R2 / R1: several start values
        measure_period(8'hFE);
        measure_period(8'hF0);
        measure_period(8'h80);
        measure_period(8'h00);
        measure_period(8'hFF);

        // R1: pulses spaced 256-N apart, each one clock wide
        begin
            int last;
            int cyc;
            int gaps;
            @(negedge clk);
            tmr_run = 1'b0; preload = 8'hF8;
            @(negedge clk);
            tmr_run = 1'b1;
            last = -1; gaps = 0; cyc = 0;
            while (gaps < 3 && cyc < 200) begin
                @(negedge clk);
                cyc++;
                if (ovf_pulse) begin
                    if (last >= 0) begin
                        gaps++;
                        checks++;
                        if (cyc - last != 8) begin
                            errors++;
                            $display("FAIL R1 pulse gap actual=%0d expected=8", cyc - last);
                        end
                    end
                    last = cyc;
                end
            end
        end

        // R3: a restart clears the toggle, with no pulse
        step(5);
        tmr_run = 1'b0;
        @(negedge clk);
        tmr_run = 1'b1;
        @(negedge clk);
        chk("R3 toggle cleared on start", pin_out, 1'b0);
        chk("R3 no pulse on start", ovf_pulse, 1'b0);

        // R6: freeze the wave while it is high
        while (!pin_out) @(negedge clk);
        tmr_run = 1'b0;
        step(40);
        chk("R6 pin frozen high", pin_out, 1'b1);
        chk("R6 no pulse while stopped", ovf_pulse, 1'b0);

        // R4: gate closed
        port_bit = 1'b0;
        #1;
        chk("R4 gate closed forces low", pin_out, 1'b0);
        tmr_run = 1'b1;
        step(30);
        chk("R4 still low while running", pin_out, 1'b0);
        port_bit = 1'b1;

        // R7: normal mode follows the port bit
        freq_sel = 1'b0;
        port_bit = 1'b1;
        #1;
        chk("R7 normal mode high", pin_out, 1'b1);
        step(7);
        port_bit = 1'b0;
        #1;
        chk("R7 normal mode low", pin_out, 1'b0);
        step(20);
        port_bit = 1'b1;
        step(20);
        freq_sel = 1'b1;
        step(50);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule